// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block places incoming network frames into host-owned receive buffers. A frame arrives as a byte stream (valid, data, last, with a ready back to the source). At the first byte the engine looks through a ring of sixteen descriptors, starting at its saved ring pointer, for one that the host has handed over. It streams the frame bytes into that descriptor's buffer, pads short frames with zeros, reports the true byte count through a length write, and hands the descriptor back to the host by rewriting its status byte.

The descriptor status bytes live inside the block and are written and read by the host through a small indexed port. Buffer bytes and lengths leave the block as write strobes with an index and offset, for an external buffer memory. On completion the engine pulses a done event, plus an interrupt request when interrupts are enabled, toward the control block. A `can_receive` output tells the source whether any descriptor is currently available.

Top module: `rx_ring_engine`

## Requirements
- R1: The ring has 16 entries; the search for a free entry wraps from index 15 back to index 0.
- R2: An entry is free only when its status byte is exactly 0x80. The search starts at the ring pointer, which is 0 after reset and advances by exactly one for each descriptor consumed.
- R3: `can_receive` is high when at least one entry holds status 0x80 and `stop` is low, and low otherwise.
- R4: Frame bytes are written to the chosen descriptor's buffer at offsets 0, 1, 2, ... in arrival order; a completed descriptor's status becomes 0x03.
- R5: The received byte count is written through `len_we`/`len_idx`/`len_val` for the chosen descriptor.
- R6: A frame shorter than 60 bytes is padded with zero bytes up to offset 59, while the recorded length stays the true count.
- R7: Completion pulses `rx_done` for one cycle; `rx_irq` pulses with it only when `inea` is high.
- R8: A frame whose first byte arrives while `stop` is high is consumed and dropped: no buffer write, no status change, no event.
- R9: When no entry is free at the first byte, the frame is consumed and discarded, `rx_miss` pulses once, and the ring pointer does not move.
- R10: A frame longer than 1544 bytes keeps only its first 1544 bytes, records length 1544, and ends with status 0x53 (error and overflow bits with the start/end bits).
- R11: The host port writes status byte `host_idx` on `host_we` and reads it combinationally on `host_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| stop | input | 1 | Engine stopped; frames dropped, nothing available |
| inea | input | 1 | Interrupt enable |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Last byte of frame |
| in_ready | output | 1 | Engine accepts a byte this cycle |
| host_we | input | 1 | Host status write strobe |
| host_idx | input | 4 | Host status entry index |
| host_wdata | input | 8 | Host status write value |
| host_rdata | output | 8 | Status byte of entry `host_idx` |
| can_receive | output | 1 | A free descriptor exists |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_idx | output | 4 | Descriptor whose buffer is written |
| buf_off | output | 11 | Byte offset in the buffer |
| buf_data | output | 8 | Byte to write |
| len_we | output | 1 | Length write strobe |
| len_idx | output | 4 | Descriptor whose length is written |
| len_val | output | 11 | Received byte count |
| rx_done | output | 1 | Frame completed pulse |
| rx_irq | output | 1 | Interrupt request pulse |
| rx_miss | output | 1 | Frame lost for lack of a descriptor |

## Verification
The assertions watch every cycle that a stopped engine never offers reception, that an interrupt never appears without a completion and the enable, that no buffer write or recorded length goes past the 1544-byte limit, that a frame's writes stay on one descriptor, and that a miss and a completion never coincide. Which descriptor the search picks, the wrap past index 15, the exact status byte rules, the zero padding, the unchanged pointer after a miss and the drop while stopped depend on the history of host writes, so only the bench's frame sequences show them, by reading the buffer, length and status results back.

// File: rtl/rx_ring_engine.sv
module rx_ring_engine #(
  parameter int IDX_W   = 4,
  parameter int MAX_LEN = 1544,
  parameter int MIN_LEN = 60,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop,
  input  logic             inea,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             in_ready,
  input  logic             host_we,
  input  logic [IDX_W-1:0] host_idx,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  output logic             can_receive,
  output logic             buf_we,
  output logic [IDX_W-1:0] buf_idx,
  output logic [LEN_W-1:0] buf_off,
  output logic [7:0]       buf_data,
  output logic             len_we,
  output logic [IDX_W-1:0] len_idx,
  output logic [LEN_W-1:0] len_val,
  output logic             rx_done,
  output logic             rx_irq,
  output logic             rx_miss
);
  localparam int RING = 1 << IDX_W;
  localparam logic [7:0] ST_FREE = 8'h80;
  localparam logic [7:0] ST_OK   = 8'h03;
  localparam logic [7:0] ST_OVF  = 8'h53;
  localparam logic [LEN_W-1:0] LMAX = LEN_W'(MAX_LEN);
  localparam logic [LEN_W-1:0] LMIN = LEN_W'(MIN_LEN);

  typedef enum logic [2:0] {IDLE, RECV, PAD, DONE, DROP} state_t;
  state_t st;

  logic [7:0]       stat [RING];
  logic [RING-1:0]  free_v;
  logic [IDX_W-1:0] rxptr, cur, fidx;
  logic [LEN_W-1:0] len, pad, nlen;
  logic             ovf, found;

  genvar g;
  generate
    for (g = 0; g < RING; g++) begin : g_free
      assign free_v[g] = (stat[g] == ST_FREE);
    end
  endgenerate

  always_comb begin
    found = 1'b0;
    fidx  = rxptr;
    for (int k = RING - 1; k >= 0; k--) begin
      if (free_v[rxptr + k[IDX_W-1:0]]) begin
        found = 1'b1;
        fidx  = rxptr + k[IDX_W-1:0];
      end
    end
  end

  wire take  = in_valid & in_ready;
  wire start = (st == IDLE) & take & ~stop & found;
  assign nlen = (len == LMAX) ? len : len + 1'b1;

  assign in_ready    = (st == IDLE) | (st == RECV) | (st == DROP);
  assign can_receive = ~stop & (|free_v);
  assign host_rdata  = stat[host_idx];

  assign buf_we   = start | ((st == RECV) & take & (len < LMAX)) | (st == PAD);
  assign buf_idx  = (st == IDLE) ? fidx : cur;
  assign buf_off  = (st == IDLE) ? '0 : (st == PAD) ? pad : len;
  assign buf_data = (st == PAD) ? 8'h00 : in_data;

  assign len_we  = (st == DONE);
  assign len_idx = cur;
  assign len_val = len;
  assign rx_done = (st == DONE);
  assign rx_irq  = (st == DONE) & inea;
  assign rx_miss = (st == IDLE) & take & ~stop & ~found;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RING; i++) stat[i] <= 8'h00;
    end else begin
      if (host_we) stat[host_idx] <= host_wdata;
      if (st == DONE) stat[cur] <= ovf ? ST_OVF : ST_OK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= IDLE;
      rxptr <= '0;
      cur   <= '0;
      len   <= '0;
      pad   <= '0;
      ovf   <= 1'b0;
    end else begin
      case (st)
        IDLE: if (take) begin
          if (!start) begin
            st <= in_last ? IDLE : DROP;
          end else begin
            cur <= fidx;
            len <= LEN_W'(1);
            ovf <= 1'b0;
            if (in_last) begin
              pad <= LEN_W'(1);
              st  <= (LMIN > LEN_W'(1)) ? PAD : DONE;
            end else begin
              st <= RECV;
            end
          end
        end
        RECV: if (take) begin
          len <= nlen;
          if (len == LMAX) ovf <= 1'b1;
          if (in_last) begin
            pad <= nlen;
            st  <= (nlen < LMIN) ? PAD : DONE;
          end
        end
        PAD: begin
          pad <= pad + 1'b1;
          if (pad == LMIN - 1'b1) st <= DONE;
        end
        DONE: begin
          rxptr <= rxptr + 1'b1;
          st    <= IDLE;
        end
        DROP: if (take && in_last) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_ring_engine_chk.sv
module rx_ring_engine_chk #(
  parameter int IDX_W   = 4,
  parameter int MAX_LEN = 1544,
  parameter int LEN_W   = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop,
  input logic             inea,
  input logic             can_receive,
  input logic             buf_we,
  input logic [IDX_W-1:0] buf_idx,
  input logic [LEN_W-1:0] buf_off,
  input logic             len_we,
  input logic [LEN_W-1:0] len_val,
  input logic             rx_done,
  input logic             rx_irq,
  input logic             rx_miss
);
  a_r3_stop_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> !can_receive);

  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (rx_done && inea));

  a_r10_off_bound: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (buf_off < LEN_W'(MAX_LEN)));

  a_r10_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    len_we |-> (len_val <= LEN_W'(MAX_LEN)));

  a_r4_idx_held: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_we && $past(buf_we)) |-> (buf_idx == $past(buf_idx)));

  a_r9_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_miss && rx_done));
endmodule

bind rx_ring_engine rx_ring_engine_chk #(.IDX_W(IDX_W), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stop(stop), .inea(inea), .can_receive(can_receive),
  .buf_we(buf_we), .buf_idx(buf_idx), .buf_off(buf_off), .len_we(len_we),
  .len_val(len_val), .rx_done(rx_done), .rx_irq(rx_irq), .rx_miss(rx_miss)
);

// File: tb/tb_rx_ring_engine.sv
`timescale 1ns/1ps
module tb_rx_ring_engine;
  logic clk = 0, rst_n = 0, stop = 0, inea = 0;
  logic in_valid = 0, in_last = 0, host_we = 0;
  logic [7:0] in_data = 0, host_wdata = 0, host_rdata, buf_data;
  logic [3:0] host_idx = 0, buf_idx, len_idx;
  logic [10:0] buf_off, len_val;
  logic in_ready, can_receive, buf_we, len_we, rx_done, rx_irq, rx_miss;

  always #10 clk = ~clk;

  rx_ring_engine dut (.*);

  typedef struct packed {logic [3:0] idx; logic [10:0] len; logic irq;} item_t;
  item_t q[$];
  int checks = 0, errors = 0, n_done = 0, n_miss = 0;
  bit finished = 0;
  logic [7:0]  bmem [0:32767];
  logic [10:0] lmem [0:15];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (buf_we) bmem[{buf_idx, buf_off}] <= buf_data;
    if (len_we) lmem[len_idx] <= len_val;
  end

  always @(negedge clk) if (rst_n) begin
    if (rx_miss) n_miss++;
    if (rx_done) begin
      n_done++;
      if (q.size() == 0) chk(0, "R7 unexpected completion", 1, 0);
      else begin
        item_t e;
        e = q.pop_front();
        chk(len_idx == e.idx, "R2 descriptor index", len_idx, e.idx);
        chk(len_val == e.len, "R5 length", len_val, e.len);
        chk(rx_irq == e.irq, "R7 irq pulse", rx_irq, e.irq);
      end
    end
  end

  function automatic logic [7:0] pat(int i, int n);
    return 8'((i * 7 + n) & 255);
  endfunction

  task automatic host_set(input int idx, input logic [7:0] v);
    @(negedge clk);
    host_we = 1; host_idx = 4'(idx); host_wdata = v;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic stat_is(input int idx, input logic [7:0] v, input string tag);
    @(negedge clk);
    host_idx = 4'(idx);
    #1 chk(host_rdata == v, tag, host_rdata, v);
  endtask

  task automatic send(input int n, input bit ok, input int idx, input bit irq);
    int l;
    l = (n > 1544) ? 1544 : n;
    if (ok) begin
      item_t e;
      e.idx = 4'(idx); e.len = 11'(l); e.irq = irq;
      q.push_back(e);
      for (int i = 0; i < 2048; i++) bmem[idx * 2048 + i] = 8'hAA;
    end
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      in_valid = 1; in_data = pat(i, n); in_last = (i == n - 1);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 0; in_last = 0;
    repeat (70) @(negedge clk);
    if (ok) begin
      int bad;
      bad = 0;
      for (int i = 0; i < l; i++) if (bmem[idx * 2048 + i] !== pat(i, n)) bad++;
      chk(bad == 0, "R4 buffer bytes", bad, 0);
      bad = 0;
      for (int i = l; i < 60; i++) if (bmem[idx * 2048 + i] !== 8'h00) bad++;
      chk(bad == 0, "R6 zero padding", bad, 0);
      chk(bmem[idx * 2048 + 1544] === 8'hAA, "R10 no write past limit", bmem[idx * 2048 + 1544], 8'hAA);
      chk(lmem[idx] == 11'(l), "R5 stored length", lmem[idx], l);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32768; i++) bmem[i] = 8'hAA;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(can_receive == 0, "R3 reset no free entry", can_receive, 0);
    chk(in_ready == 1, "R4 reset ready", in_ready, 1);
    chk(rx_done == 0, "R7 reset no done", rx_done, 0);

    for (int i = 0; i < 4; i++) host_set(i, 8'h80);
    stat_is(2, 8'h80, "R11 host readback");
    @(negedge clk);
    chk(can_receive == 1, "R3 free entries", can_receive, 1);

    stop = 1;
    @(negedge clk);
    chk(can_receive == 0, "R3 stop blocks", can_receive, 0);
    send(10, 0, 0, 0);
    chk(n_done == 0 && n_miss == 0, "R8 dropped no event", n_done + n_miss, 0);
    chk(bmem[0] === 8'hAA, "R8 no buffer write", bmem[0], 8'hAA);
    stat_is(0, 8'h80, "R8 status unchanged");
    stop = 0;

    send(100, 1, 0, 0);
    stat_is(0, 8'h03, "R4 completed status");
    send(20, 1, 1, 0);

    host_set(2, 8'h81);
    send(64, 1, 3, 0);
    stat_is(2, 8'h81, "R2 non-exact status untouched");
    @(negedge clk);
    chk(can_receive == 0, "R3 no exact free entry", can_receive, 0);

    send(30, 0, 0, 0);
    chk(n_miss == 1, "R9 miss pulse", n_miss, 1);

    inea = 1;
    host_set(5, 8'h80);
    send(61, 1, 5, 1);

    host_set(4, 8'h80);
    host_set(6, 8'h80);
    send(1600, 1, 4, 1);
    stat_is(4, 8'h53, "R10 overflow status");

    send(1, 1, 6, 1);
    host_set(1, 8'h80);
    send(75, 1, 1, 1);
    stat_is(1, 8'h03, "R1 wrapped entry completed");
    @(negedge clk);
    chk(can_receive == 0, "R3 ring exhausted", can_receive, 0);
    chk(q.size() == 0, "R7 all completions seen", q.size(), 0);
    chk(n_done == 7, "R7 done count", n_done, 7);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule